// File: doc/BRIEF.md
# Configurable Word-Length Serial Transmitter

This block is the transmit half of a synchronous serial port. Software, or a DMA engine, hands it 24-bit words through a valid/ready load port. On each frame start the block captures one word and shifts it out most-significant bit first, one bit per bit-clock enable. The word-length code is sampled at that moment and sets the frame to 8, 12, 16, 24 or 32 bits. Shorter frames use the top bits of the word. The two 32-bit codes pad the 24 data bits with eight copies of a single bit. One code repeats the final data bit after the data. The other repeats the first data bit before the data.

The block also drives an auxiliary pin. When synchronous mode is on, the second transmitter is off and the pin is set as an output, a select bit chooses what the pin carries. With the select bit set, the pin is a driver enable for an external line buffer and is high exactly while frame bits are on the serial output. With it clear, the pin carries a software flag. If no new word has arrived by the next frame start, the block raises an underrun flag and resends the last word. A reserved length code starts no frame and raises an error flag instead.

Top module: `wl_serial_tx`

## Requirements
- R1: After reset, sdo, aux_out, wl_err and underrun are 0 and load_ready is 1.
- R2: Length codes 000, 001, 010 and 011 give frames of 8, 12, 16 and 24 bits, sent MSB first from bits 23 downward of the word.
- R3: Code 100 gives a 32-bit frame: word bits 23..0 first, then bit 0 repeated for eight more bit periods.
- R4: Code 101 gives a 32-bit frame: bit 23 for eight bit periods, then word bits 23..0.
- R5: Codes 110 and 111 start no frame. sdo stays 0, the held word is not consumed (load_ready stays 0) and wl_err goes to 1. wl_err goes back to 0 at the next frame start with a valid code.
- R6: load_ready is 1 while the holding buffer is empty. An accepted load drops load_ready on the next cycle. A frame start takes the held word and raises load_ready again.
- R7: A frame start with an empty holding buffer sets underrun to 1 and resends the previous word. A start with a held word sets underrun to 0.
- R8: The length code is captured at frame start. Changing it during a frame does not change that frame's length, and the new code applies from the next frame.
- R9: With aux_sel_de=1, sync_mode=1, tx2_en=0 and aux_dir_out=1, aux_out is 1 in exactly the bit periods that carry frame bits (padding included) and 0 otherwise.
- R10: With aux_sel_de=0 under the same three conditions, aux_out equals flag_bit.
- R11: If sync_mode=0, tx2_en=1 or aux_dir_out=0, aux_out is 0.
- R12: The frame advances only on cycles with bit_en=1. frame_start without bit_en has no effect. The first bit appears on sdo after the clock edge that sees frame_start and bit_en.
- R13: A frame start coinciding with the bit_en that ends the final bit begins the next frame with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_valid | input | 1 | Load request |
| load_data | input | 24 | Word to transmit |
| load_ready | output | 1 | Holding buffer empty |
| bit_en | input | 1 | Bit-clock enable, one pulse per bit period |
| frame_start | input | 1 | Frame sync, honoured with bit_en |
| wl_code | input | 3 | Word-length code |
| sync_mode | input | 1 | Synchronous mode active |
| tx2_en | input | 1 | Second transmitter enabled |
| aux_dir_out | input | 1 | Auxiliary pin set as output |
| aux_sel_de | input | 1 | 1: pin is driver enable, 0: pin is flag |
| flag_bit | input | 1 | Software serial flag |
| sdo | output | 1 | Serial data out |
| aux_out | output | 1 | Auxiliary pin output |
| wl_err | output | 1 | Reserved length code seen at last start |
| underrun | output | 1 | Last frame resent an old word |

## Verification
Each serial bit, the driver enable, wl_err and underrun are registered. They take their new values at the clock edge where bit_en is high and are checked one clock later. load_ready falls at the edge that accepts a load. In flag mode, aux_out follows flag_bit and the routing inputs within the same cycle. The bench changes inputs on the falling edge and reads outputs at the next falling edge, so every check lands one register stage after its stimulus. Periods without bit_en are inserted to show that nothing advances between enables.

// File: rtl/wl_tx_pkg.sv
package wl_tx_pkg;

    typedef enum logic [1:0] {
        PAD_NONE = 2'd0,
        PAD_TAIL = 2'd1,
        PAD_HEAD = 2'd2
    } pad_e;

    localparam logic [2:0] WLC_A    = 3'b000;
    localparam logic [2:0] WLC_B    = 3'b001;
    localparam logic [2:0] WLC_C    = 3'b010;
    localparam logic [2:0] WLC_FULL = 3'b011;
    localparam logic [2:0] WLC_TAIL = 3'b100;
    localparam logic [2:0] WLC_HEAD = 3'b101;

endpackage

// File: rtl/wl_decode.sv
module wl_decode
    import wl_tx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int PAD_W  = 8,
    parameter int LEN_A  = 8,
    parameter int LEN_B  = 12,
    parameter int LEN_C  = 16,
    localparam int CNT_W = $clog2(DATA_W + PAD_W)
) (
    input  logic [2:0]       code,
    output logic             cfg_valid,
    output pad_e             cfg_pad,
    output logic [CNT_W-1:0] cfg_last
);
    always_comb begin
        cfg_valid = 1'b1;
        cfg_pad   = PAD_NONE;
        cfg_last  = CNT_W'(LEN_A - 1);
        case (code)
            WLC_A:    cfg_last = CNT_W'(LEN_A - 1);
            WLC_B:    cfg_last = CNT_W'(LEN_B - 1);
            WLC_C:    cfg_last = CNT_W'(LEN_C - 1);
            WLC_FULL: cfg_last = CNT_W'(DATA_W - 1);
            WLC_TAIL: begin
                cfg_pad  = PAD_TAIL;
                cfg_last = CNT_W'(DATA_W + PAD_W - 1);
            end
            WLC_HEAD: begin
                cfg_pad  = PAD_HEAD;
                cfg_last = CNT_W'(DATA_W + PAD_W - 1);
            end
            default:  cfg_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ready,
    input  logic              take,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_word
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_q, h_d;
    logic  fire;

    assign load_ready = !h_q.full;
    assign fire       = load_valid && !h_q.full;
    assign hold_full  = h_q.full;
    assign hold_word  = h_q.data;

    always_comb begin
        h_d = h_q;
        if (fire) begin
            h_d.full = 1'b1;
            h_d.data = load_data;
        end else if (take) begin
            h_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assert_load_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_ready) |=> !load_ready);
    assert_keep_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.full && !take) |=> (h_q.full && $stable(h_q.data)));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import wl_tx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int PAD_W  = 8,
    localparam int CNT_W = $clog2(DATA_W + PAD_W),
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_start,
    input  logic              cfg_valid,
    input  pad_e              cfg_pad,
    input  logic [CNT_W-1:0]  cfg_last,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_word,
    output logic              take,
    output logic              sdo,
    output logic              active,
    output logic              wl_err,
    output logic              underrun
);
    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  last;
        pad_e              pad;
        logic [DATA_W-1:0] word;
        logic              sdo;
        logic              wl_err;
        logic              underrun;
    } shf_t;

    shf_t s_q, s_d;
    logic at_last;
    logic start_ok;

    // Bit k of the frame, counted from the first bit sent.
    function automatic logic pick_bit(input logic [DATA_W-1:0] w,
                                      input pad_e p,
                                      input logic [CNT_W-1:0] k);
        int               pos;
        logic [IDX_W-1:0] bi;
        pos = int'(k);
        if (p == PAD_HEAD) pos = (pos < PAD_W) ? 0 : pos - PAD_W;
        if (pos >= DATA_W) pos = DATA_W - 1;
        bi = IDX_W'(DATA_W - 1 - pos);
        return w[bi];
    endfunction

    assign at_last  = s_q.active && (s_q.cnt == s_q.last);
    assign start_ok = bit_en && frame_start && (!s_q.active || at_last);

    always_comb begin
        logic [DATA_W-1:0] nw;
        s_d  = s_q;
        take = 1'b0;
        nw   = hold_full ? hold_word : s_q.word;
        if (start_ok) begin
            if (cfg_valid) begin
                take       = hold_full;
                s_d.underrun = !hold_full;
                s_d.wl_err = 1'b0;
                s_d.active = 1'b1;
                s_d.cnt    = '0;
                s_d.last   = cfg_last;
                s_d.pad    = cfg_pad;
                s_d.word   = nw;
                s_d.sdo    = pick_bit(nw, cfg_pad, '0);
            end else begin
                s_d.wl_err = 1'b1;
                s_d.active = 1'b0;
                s_d.sdo    = 1'b0;
            end
        end else if (bit_en && s_q.active) begin
            if (at_last) begin
                s_d.active = 1'b0;
                s_d.sdo    = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
                s_d.sdo = pick_bit(s_q.word, s_q.pad, s_q.cnt + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo      = s_q.sdo;
    assign active   = s_q.active;
    assign wl_err   = s_q.wl_err;
    assign underrun = s_q.underrun;

    assert_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_start && !s_q.active && cfg_valid) |=> active);
    assert_no_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !bit_en) |=> ($stable(s_q.cnt) && $stable(sdo) && active));
    assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_start && !s_q.active && !cfg_valid) |=> (wl_err && !active));
    assert_len_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !(bit_en && at_last)) |=> ($stable(s_q.last) && $stable(s_q.pad)));
    assert_resend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_start && !s_q.active && cfg_valid && !hold_full)
        |=> (underrun && $stable(s_q.word)));
endmodule

// File: rtl/aux_pin_mux.sv
module aux_pin_mux (
    input  logic sync_mode,
    input  logic tx2_en,
    input  logic aux_dir_out,
    input  logic aux_sel_de,
    input  logic flag_bit,
    input  logic tx_active,
    output logic aux_out
);
    logic routed;

    always_comb begin
        routed  = sync_mode && !tx2_en && aux_dir_out;
        aux_out = 1'b0;
        if (routed) aux_out = aux_sel_de ? tx_active : flag_bit;
    end
endmodule

// File: rtl/wl_serial_tx.sv
module wl_serial_tx
    import wl_tx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int PAD_W  = 8,
    localparam int CNT_W = $clog2(DATA_W + PAD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ready,
    input  logic              bit_en,
    input  logic              frame_start,
    input  logic [2:0]        wl_code,
    input  logic              sync_mode,
    input  logic              tx2_en,
    input  logic              aux_dir_out,
    input  logic              aux_sel_de,
    input  logic              flag_bit,
    output logic              sdo,
    output logic              aux_out,
    output logic              wl_err,
    output logic              underrun
);
    logic              cfg_valid;
    pad_e              cfg_pad;
    logic [CNT_W-1:0]  cfg_last;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_word;
    logic              tx_active;

    wl_decode #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_decode (
        .code      (wl_code),
        .cfg_valid (cfg_valid),
        .cfg_pad   (cfg_pad),
        .cfg_last  (cfg_last)
    );

    tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_data  (load_data),
        .load_ready (load_ready),
        .take       (take),
        .hold_full  (hold_full),
        .hold_word  (hold_word)
    );

    tx_shifter #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .frame_start (frame_start),
        .cfg_valid   (cfg_valid),
        .cfg_pad     (cfg_pad),
        .cfg_last    (cfg_last),
        .hold_full   (hold_full),
        .hold_word   (hold_word),
        .take        (take),
        .sdo         (sdo),
        .active      (tx_active),
        .wl_err      (wl_err),
        .underrun    (underrun)
    );

    aux_pin_mux u_aux (
        .sync_mode   (sync_mode),
        .tx2_en      (tx2_en),
        .aux_dir_out (aux_dir_out),
        .aux_sel_de  (aux_sel_de),
        .flag_bit    (flag_bit),
        .tx_active   (tx_active),
        .aux_out     (aux_out)
    );

    assert_aux_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode || tx2_en || !aux_dir_out) |-> !aux_out);
    assert_take_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_ready && bit_en && frame_start && !tx_active && cfg_valid) |=> load_ready);
endmodule

// File: tb/wl_serial_tx_tb.sv
module wl_serial_tx_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [23:0] load_data = '0;
    logic        load_ready;
    logic        bit_en = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  wl_code = 3'b000;
    logic        sync_mode = 1'b0;
    logic        tx2_en = 1'b0;
    logic        aux_dir_out = 1'b0;
    logic        aux_sel_de = 1'b0;
    logic        flag_bit = 1'b0;
    logic        sdo, aux_out, wl_err, underrun;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    wl_serial_tx u_dut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
        .load_ready(load_ready), .bit_en(bit_en), .frame_start(frame_start),
        .wl_code(wl_code), .sync_mode(sync_mode), .tx2_en(tx2_en),
        .aux_dir_out(aux_dir_out), .aux_sel_de(aux_sel_de), .flag_bit(flag_bit),
        .sdo(sdo), .aux_out(aux_out), .wl_err(wl_err), .underrun(underrun)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [2:0] c);
        case (c)
            3'b000:  return 8;
            3'b001:  return 12;
            3'b010:  return 16;
            3'b011:  return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic exp_bit(input logic [23:0] w, input logic [2:0] c, input int k);
        if (c == 3'b101) return (k < 8) ? w[23] : w[23-(k-8)];
        if (c == 3'b100 && k >= 24) return w[0];
        return w[23-k];
    endfunction

    // Inputs change on the falling edge; outputs are read at the next one.
    task automatic step(input logic en, input logic fs);
        bit_en = en;
        frame_start = fs;
        @(negedge clk);
        bit_en = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic load_word(input logic [23:0] w, input string req);
        check(req, "ready before load", load_ready, 1);
        load_valid = 1'b1;
        load_data = w;
        @(negedge clk);
        load_valid = 1'b0;
        check(req, "ready after load", load_ready, 0);
    endtask

    task automatic send_frame(input logic [2:0] c, input logic [23:0] w, input string req);
        wl_code = c;
        step(1'b1, 1'b1);
        check(req, "bit 0", sdo, exp_bit(w, c, 0));
        check("R9", "enable at bit 0", aux_out, 1);
        for (int k = 1; k < exp_len(c); k++) begin
            step(1'b1, 1'b0);
            check(req, $sformatf("bit %0d", k), sdo, exp_bit(w, c, k));
        end
        check("R9", "enable at final bit", aux_out, 1);
    endtask

    task automatic end_frame(input string req);
        step(1'b1, 1'b0);
        check(req, "sdo idle after frame", sdo, 0);
        check("R9", "enable off after frame", aux_out, 0);
    endtask

    task automatic t_reset;
        check("R1", "sdo", sdo, 0);
        check("R1", "aux_out", aux_out, 0);
        check("R1", "load_ready", load_ready, 1);
        check("R1", "wl_err", wl_err, 0);
        check("R1", "underrun", underrun, 0);
    endtask

    task automatic t_lengths;
        logic [23:0] ws [4];
        ws[0] = 24'hB4_9E_21; ws[1] = 24'h6D_3A_C5; ws[2] = 24'hE1_5B_7C; ws[3] = 24'h93_C6_0F;
        for (int i = 0; i < 4; i++) begin
            load_word(ws[i], "R6");
            send_frame(3'(i), ws[i], "R2");
            check("R6", "ready after start", load_ready, 1);
            end_frame("R2");
        end
    endtask

    task automatic t_pad;
        load_word(24'h5A_3C_71, "R6"); send_frame(3'b100, 24'h5A_3C_71, "R3"); end_frame("R3");
        load_word(24'hD2_B4_6E, "R6"); send_frame(3'b100, 24'hD2_B4_6E, "R3"); end_frame("R3");
        load_word(24'hC3_5A_1E, "R6"); send_frame(3'b101, 24'hC3_5A_1E, "R4"); end_frame("R4");
        load_word(24'h4B_A5_97, "R6"); send_frame(3'b101, 24'h4B_A5_97, "R4"); end_frame("R4");
    endtask

    task automatic t_reserved;
        load_word(24'h9C_6B_35, "R6");
        wl_code = 3'b110;
        step(1'b1, 1'b1);
        check("R5", "wl_err code 110", wl_err, 1);
        check("R5", "sdo code 110", sdo, 0);
        check("R5", "no enable code 110", aux_out, 0);
        check("R5", "word kept", load_ready, 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0);
            check("R5", "sdo stays idle", sdo, 0);
        end
        wl_code = 3'b111;
        step(1'b1, 1'b1);
        check("R5", "wl_err code 111", wl_err, 1);
        check("R5", "word still kept", load_ready, 0);
        send_frame(3'b000, 24'h9C_6B_35, "R5");
        check("R5", "wl_err cleared", wl_err, 0);
        end_frame("R5");
    endtask

    task automatic t_underrun;
        send_frame(3'b010, 24'h9C_6B_35, "R7");
        check("R7", "underrun set", underrun, 1);
        end_frame("R7");
        load_word(24'h27_E8_D1, "R6");
        send_frame(3'b001, 24'h27_E8_D1, "R7");
        check("R7", "underrun cleared", underrun, 0);
        end_frame("R7");
    endtask

    task automatic t_code_change;
        load_word(24'h71_00_00, "R6");
        wl_code = 3'b000;
        step(1'b1, 1'b1);
        check("R8", "bit 0", sdo, exp_bit(24'h71_00_00, 3'b000, 0));
        for (int k = 1; k < 8; k++) begin
            if (k == 2) wl_code = 3'b011;
            step(1'b1, 1'b0);
            check("R8", $sformatf("bit %0d", k), sdo, exp_bit(24'h71_00_00, 3'b000, k));
        end
        step(1'b1, 1'b0);
        check("R8", "frame ends at 8 bits", aux_out, 0);
        load_word(24'hA6_59_C3, "R6");
        send_frame(3'b011, 24'hA6_59_C3, "R8");
        end_frame("R8");
    endtask

    task automatic t_gating;
        load_word(24'hAA_AA_AA, "R6");
        wl_code = 3'b000;
        step(1'b1, 1'b1);
        check("R12", "first bit", sdo, 1);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            check("R12", "bit held", sdo, 1);
            check("R12", "enable held", aux_out, 1);
        end
        step(1'b1, 1'b0);
        check("R12", "second bit", sdo, 0);
        for (int i = 0; i < 2; i++) begin
            step(1'b0, 1'b1);
            check("R12", "start without enable ignored", sdo, 0);
        end
        for (int k = 2; k < 8; k++) begin
            step(1'b1, 1'b0);
            check("R12", $sformatf("bit %0d", k), sdo, exp_bit(24'hAA_AA_AA, 3'b000, k));
        end
        end_frame("R12");
        step(1'b0, 1'b1);
        check("R12", "idle start without enable", aux_out, 0);
        check("R12", "no underrun from ignored start", underrun, 0);
    endtask

    task automatic t_back_to_back;
        load_word(24'h3C_00_00, "R6");
        send_frame(3'b000, 24'h3C_00_00, "R13");
        load_word(24'hC0_00_00, "R6");
        send_frame(3'b000, 24'hC0_00_00, "R13");
        check("R13", "no underrun", underrun, 0);
        end_frame("R13");
    endtask

    task automatic t_aux;
        aux_sel_de = 1'b0;
        flag_bit = 1'b1; @(negedge clk);
        check("R10", "flag high", aux_out, 1);
        flag_bit = 1'b0; @(negedge clk);
        check("R10", "flag low", aux_out, 0);
        flag_bit = 1'b1;
        tx2_en = 1'b1; @(negedge clk);
        check("R11", "tx2 enabled", aux_out, 0);
        tx2_en = 1'b0; sync_mode = 1'b0; @(negedge clk);
        check("R11", "async mode", aux_out, 0);
        sync_mode = 1'b1; aux_dir_out = 1'b0; @(negedge clk);
        check("R11", "pin as input", aux_out, 0);
        aux_dir_out = 1'b1; @(negedge clk);
        check("R10", "flag restored", aux_out, 1);
        aux_sel_de = 1'b1; tx2_en = 1'b1;
        load_word(24'hFF_00_FF, "R6");
        wl_code = 3'b000;
        step(1'b1, 1'b1);
        check("R11", "frame runs", sdo, 1);
        check("R11", "no enable with tx2 on", aux_out, 0);
        for (int k = 1; k < 9; k++) step(1'b1, 1'b0);
        tx2_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        sync_mode = 1'b1; tx2_en = 1'b0; aux_dir_out = 1'b1; aux_sel_de = 1'b1;
        t_lengths();
        t_pad();
        t_reserved();
        t_underrun();
        t_code_change();
        t_gating();
        t_back_to_back();
        t_aux();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule